// File: doc/BRIEF.md
# Authentication-Gated Power Enable Controller

This block decides whether a power path may be switched on. Once the supply reports power-good and a session is requested, it issues a challenge. The challenge carries a nonce taken from an entropy input and a rolling counter value. An external verifier computes the cryptographic check and returns a pass/fail flag together with the counter value the device echoed. The hardware enable is granted only when that answer arrives inside a bounded window, reports a pass, and carries a counter newer than the last one accepted. No other path can raise the enable.

When a session fails, the block falls into one of three configured modes: full disconnect, a limited trickle-current mode, or a maintenance power cap. The two limited modes are time-boxed and drop back to disconnect when their timer runs out. Consecutive failures are counted, and reaching the retry limit starts a cool-down during which no challenge may be issued. A supply drop during a session or while granted clears the session. A tamper input aborts any session and latches an alert that stays set until a service clear is given.

Top module: `auth_power_gate`

## Requirements
- R1: `en_o` rises only in the cycle after a response is accepted with pass set, in-window, with a fresh counter, while power-good is high; `pg_o` always equals `en_o`.
- R2: A challenge (`chal_valid_o` high for exactly one cycle) is issued only from idle, with `pwr_good_i` high, `start_req_i` high, no cool-down running and no tamper. `chal_nonce_o` holds the seed sampled at issue. `chal_ctr_o` is 1 on the first challenge after reset and grows by one with each challenge.
- R3: A response whose counter is less than or equal to the last accepted counter is a replay: the session fails with cause 2 even when the pass flag is set.
- R4: A response with the pass flag low and a fresh counter fails the session with cause 1.
- R5: If no response arrives within WINDOW_CYC cycles after the challenge, the session fails with cause 3.
- R6: On failure, `policy_i` selects the mode. Values 0 and 3 select disconnect (EN and LIMIT low, `lim_mode_o`=0). Value 1 selects trickle (LIMIT high, `lim_mode_o`=1). Value 2 selects cap (LIMIT high, `lim_mode_o`=2). EN stays low in all three.
- R7: Trickle and cap last DEG_CYC cycles and then fall to disconnect. A loss of power-good ends them at once. No challenge is issued while they last.
- R8: Power-good falling while waiting for a response or while granted returns the block to idle with EN low and cause 5.
- R9: The RETRY_MAX-th consecutive failure starts a cool-down of COOL_CYC cycles that blocks new challenges. A successful session resets the failure count.
- R10: Tamper sets cause 4 and aborts a pending or granted session. Cause 4 is not replaced by later events until `svc_clear_i` is given, and sessions may still succeed while it is held.
- R11: `alert_o` is high exactly when `cause_o` is nonzero. A cause stays latched until `svc_clear_i`, or until a newer non-tamper cause replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supply power-good |
| start_req_i | input | 1 | Request to open a session |
| nonce_seed_i | input | NONCE_W | Entropy used as challenge nonce |
| chal_valid_o | output | 1 | One-cycle challenge strobe |
| chal_nonce_o | output | NONCE_W | Nonce of the latest challenge |
| chal_ctr_o | output | CTR_W | Rolling counter of the latest challenge |
| resp_valid_i | input | 1 | Verification result strobe |
| resp_pass_i | input | 1 | Verification passed |
| resp_ctr_i | input | CTR_W | Counter echoed by the device |
| tamper_i | input | 1 | Tamper event |
| svc_clear_i | input | 1 | Service clear of latched cause |
| policy_i | input | 2 | Failure mode select |
| en_o | output | 1 | Power path enable |
| pg_o | output | 1 | Permitted-state indication |
| limit_o | output | 1 | Degraded power active |
| lim_mode_o | output | 2 | 0 none, 1 trickle, 2 cap |
| alert_o | output | 1 | Latched alert |
| cause_o | output | 3 | 0 none, 1 bad MAC, 2 replay, 3 timeout, 4 tamper, 5 brownout |

## Verification
The cool-down after repeated failures is the hardest state to reach. It takes RETRY_MAX consecutive failures with no success between them. Only then does a held start request go unanswered for a long stretch. The stimulus builds this with three failures of different kinds in a row: a replayed counter, a rejected MAC under trickle, and a timeout under disconnect. Afterwards it holds the start request and counts the cycles until the next challenge appears. A tamper pulse in the middle of a pending session, followed by a successful session and a brownout while the tamper cause is still latched, covers the stickiness of cause 4.

// File: rtl/ag_pkg.sv
package ag_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_GRANT   = 2'd2,
    ST_DEGRADE = 2'd3
  } ag_state_e;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_MAC     = 3'd1,
    CZ_REPLAY  = 3'd2,
    CZ_TIMEOUT = 3'd3,
    CZ_TAMPER  = 3'd4,
    CZ_BROWN   = 3'd5
  } ag_cause_e;

  localparam logic [1:0] POL_TRICKLE = 2'd1;
  localparam logic [1:0] POL_CAP     = 2'd2;

  localparam logic [1:0] LIM_NONE    = 2'd0;
  localparam logic [1:0] LIM_TRICKLE = 2'd1;
  localparam logic [1:0] LIM_CAP     = 2'd2;

endpackage

// File: rtl/ag_countdown.sv
// Loadable down-counter; busy while nonzero, last in the final counted cycle.
module ag_countdown #(
  parameter int unsigned LOAD_VAL = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned W = $clog2(LOAD_VAL + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= W'(LOAD_VAL);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/ag_retry_tracker.sv
// Counts consecutive failed sessions; flags the one that reaches the limit.
module ag_retry_tracker #(
  parameter int unsigned RETRY_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_i,
  input  logic pass_i,
  output logic limit_hit_o
);
  localparam int unsigned W = $clog2(RETRY_MAX + 1);

  logic [W-1:0] fails_q;

  assign limit_hit_o = fail_i && (fails_q == W'(RETRY_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fails_q <= '0;
    end else if (pass_i || limit_hit_o) begin
      fails_q <= '0;
    end else if (fail_i) begin
      fails_q <= fails_q + W'(1);
    end
  end
endmodule

// File: rtl/ag_cause_latch.sv
// Holds the last alert cause; tamper is sticky until a service clear.
module ag_cause_latch
  import ag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tamper_i,
  input  logic      clear_i,
  input  ag_cause_e event_i,
  output ag_cause_e cause_o,
  output logic      alert_o
);
  ag_cause_e cause_q, cause_n;
  logic      alert_q;

  always_comb begin
    cause_n = cause_q;
    if (tamper_i) begin
      cause_n = CZ_TAMPER;
    end else if (clear_i) begin
      cause_n = CZ_NONE;
    end else if (cause_q == CZ_TAMPER) begin
      cause_n = CZ_TAMPER;
    end else if (event_i != CZ_NONE) begin
      cause_n = event_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= CZ_NONE;
      alert_q <= 1'b0;
    end else begin
      cause_q <= cause_n;
      alert_q <= (cause_n != CZ_NONE);
    end
  end

  assign cause_o = cause_q;
  assign alert_o = alert_q;
endmodule

// File: rtl/auth_power_gate.sv
module auth_power_gate
  import ag_pkg::*;
#(
  parameter int unsigned NONCE_W    = 32,
  parameter int unsigned CTR_W      = 16,
  parameter int unsigned WINDOW_CYC = 20,
  parameter int unsigned RETRY_MAX  = 3,
  parameter int unsigned COOL_CYC   = 50,
  parameter int unsigned DEG_CYC    = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_good_i,
  input  logic               start_req_i,
  input  logic [NONCE_W-1:0] nonce_seed_i,
  output logic               chal_valid_o,
  output logic [NONCE_W-1:0] chal_nonce_o,
  output logic [CTR_W-1:0]   chal_ctr_o,
  input  logic               resp_valid_i,
  input  logic               resp_pass_i,
  input  logic [CTR_W-1:0]   resp_ctr_i,
  input  logic               tamper_i,
  input  logic               svc_clear_i,
  input  logic [1:0]         policy_i,
  output logic               en_o,
  output logic               pg_o,
  output logic               limit_o,
  output logic [1:0]         lim_mode_o,
  output logic               alert_o,
  output logic [2:0]         cause_o
);

  ag_state_e           st_q, st_n;
  logic [1:0]          mode_q, mode_n;
  logic [CTR_W-1:0]    tx_ctr_q, last_ok_q;
  logic [NONCE_W-1:0]  nonce_q;
  logic                chal_q, en_q, pg_q, lim_q;

  logic                issue, fail, pass, deg_load, cool_load;
  ag_cause_e           evt;
  ag_cause_e           cause_w;
  logic                win_busy, win_last;
  logic                cool_busy, cool_last;
  logic                deg_busy, deg_last;
  logic                limit_hit;

  // Response window, retry cool-down and degraded-mode timers
  ag_countdown #(.LOAD_VAL(WINDOW_CYC)) u_win (
    .clk(clk), .rst(rst), .load_i(issue), .busy_o(win_busy), .last_o(win_last)
  );

  ag_countdown #(.LOAD_VAL(COOL_CYC)) u_cool (
    .clk(clk), .rst(rst), .load_i(cool_load), .busy_o(cool_busy), .last_o(cool_last)
  );

  ag_countdown #(.LOAD_VAL(DEG_CYC)) u_deg (
    .clk(clk), .rst(rst), .load_i(deg_load), .busy_o(deg_busy), .last_o(deg_last)
  );

  ag_retry_tracker #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk(clk), .rst(rst), .fail_i(fail), .pass_i(pass), .limit_hit_o(limit_hit)
  );

  assign cool_load = limit_hit;

  ag_cause_latch u_cause (
    .clk(clk), .rst(rst), .tamper_i(tamper_i), .clear_i(svc_clear_i),
    .event_i(evt), .cause_o(cause_w), .alert_o(alert_o)
  );

  // Session control
  always_comb begin
    st_n     = st_q;
    mode_n   = mode_q;
    issue    = 1'b0;
    fail     = 1'b0;
    pass     = 1'b0;
    deg_load = 1'b0;
    evt      = CZ_NONE;

    unique case (st_q)
      ST_IDLE: begin
        if (pwr_good_i && start_req_i && !cool_busy && !tamper_i) begin
          issue = 1'b1;
          st_n  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tamper_i) begin
          st_n = ST_IDLE;
        end else if (!pwr_good_i) begin
          st_n = ST_IDLE;
          evt  = CZ_BROWN;
        end else if (resp_valid_i) begin
          if (resp_ctr_i <= last_ok_q) begin
            fail = 1'b1;
            evt  = CZ_REPLAY;
          end else if (!resp_pass_i) begin
            fail = 1'b1;
            evt  = CZ_MAC;
          end else begin
            pass = 1'b1;
            st_n = ST_GRANT;
          end
        end else if (win_last || !win_busy) begin
          fail = 1'b1;
          evt  = CZ_TIMEOUT;
        end
      end
      ST_GRANT: begin
        if (tamper_i) begin
          st_n = ST_IDLE;
        end else if (!pwr_good_i) begin
          st_n = ST_IDLE;
          evt  = CZ_BROWN;
        end
      end
      ST_DEGRADE: begin
        if (!pwr_good_i || deg_last || !deg_busy) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (fail) begin
      if (policy_i == POL_TRICKLE) begin
        st_n     = ST_DEGRADE;
        deg_load = 1'b1;
        mode_n   = LIM_TRICKLE;
      end else if (policy_i == POL_CAP) begin
        st_n     = ST_DEGRADE;
        deg_load = 1'b1;
        mode_n   = LIM_CAP;
      end else begin
        st_n     = ST_IDLE;
      end
    end

    if (st_n != ST_DEGRADE) begin
      mode_n = LIM_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mode_q    <= LIM_NONE;
      tx_ctr_q  <= '0;
      last_ok_q <= '0;
      nonce_q   <= '0;
      chal_q    <= 1'b0;
      en_q      <= 1'b0;
      pg_q      <= 1'b0;
      lim_q     <= 1'b0;
    end else begin
      st_q   <= st_n;
      mode_q <= mode_n;
      chal_q <= issue;
      en_q   <= (st_n == ST_GRANT);
      pg_q   <= (st_n == ST_GRANT);
      lim_q  <= (st_n == ST_DEGRADE);
      if (issue) begin
        tx_ctr_q <= tx_ctr_q + CTR_W'(1);
        nonce_q  <= nonce_seed_i;
      end
      if (pass) begin
        last_ok_q <= resp_ctr_i;
      end
    end
  end

  assign chal_valid_o = chal_q;
  assign chal_nonce_o = nonce_q;
  assign chal_ctr_o   = tx_ctr_q;
  assign en_o         = en_q;
  assign pg_o         = pg_q;
  assign limit_o      = lim_q;
  assign lim_mode_o   = mode_q;
  assign cause_o      = cause_w;

endmodule

// File: rtl/ag_checker.sv
module ag_checker #(
  parameter int unsigned CTR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_good_i,
  input logic             resp_valid_i,
  input logic             resp_pass_i,
  input logic             tamper_i,
  input logic             chal_valid_o,
  input logic [CTR_W-1:0] chal_ctr_o,
  input logic             en_o,
  input logic             pg_o,
  input logic             limit_o,
  input logic             alert_o,
  input logic [2:0]       cause_o
);

  a_r1_pg_follows_en: assert property (@(posedge clk) disable iff (rst)
    pg_o == en_o);

  a_r1_en_needs_pass: assert property (@(posedge clk) disable iff (rst)
    $rose(en_o) |-> $past(resp_valid_i && resp_pass_i && pwr_good_i));

  a_r2_issue_needs_power: assert property (@(posedge clk) disable iff (rst)
    chal_valid_o |-> $past(pwr_good_i));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    chal_valid_o |=> !chal_valid_o);

  a_r2_ctr_step: assert property (@(posedge clk) disable iff (rst)
    chal_valid_o |-> chal_ctr_o == $past(chal_ctr_o) + CTR_W'(1));

  a_r6_limit_without_en: assert property (@(posedge clk) disable iff (rst)
    limit_o |-> !en_o);

  a_r8_brownout_drops_en: assert property (@(posedge clk) disable iff (rst)
    (en_o && !pwr_good_i) |=> !en_o);

  a_r10_tamper_latched: assert property (@(posedge clk) disable iff (rst)
    ($past(tamper_i) && !$past(rst)) |-> cause_o == 3'd4);

  a_r10_tamper_drops_en: assert property (@(posedge clk) disable iff (rst)
    (en_o && tamper_i) |=> !en_o);

  a_r11_alert_matches_cause: assert property (@(posedge clk) disable iff (rst)
    alert_o == (cause_o != 3'd0));

endmodule

bind auth_power_gate ag_checker #(.CTR_W(CTR_W)) u_ag_checker (
  .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .resp_valid_i(resp_valid_i),
  .resp_pass_i(resp_pass_i), .tamper_i(tamper_i), .chal_valid_o(chal_valid_o),
  .chal_ctr_o(chal_ctr_o), .en_o(en_o), .pg_o(pg_o), .limit_o(limit_o),
  .alert_o(alert_o), .cause_o(cause_o)
);

// File: tb/tb_auth_power_gate.sv
module tb_auth_power_gate;
  localparam int NW   = 32;
  localparam int CW   = 16;
  localparam int WIN  = 20;
  localparam int RMAX = 3;
  localparam int COOL = 50;
  localparam int DEG  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0, start_req = 1'b0, resp_valid = 1'b0, resp_pass = 1'b0;
  logic tamper = 1'b0, svc_clear = 1'b0;
  logic [NW-1:0] seed = 32'h1234_5678;
  logic [CW-1:0] resp_ctr = '0;
  logic [1:0]    policy = 2'd0;

  logic          chal_valid, en, pg, limit, alert;
  logic [NW-1:0] chal_nonce;
  logic [CW-1:0] chal_ctr;
  logic [1:0]    lim_mode;
  logic [2:0]    cause;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  auth_power_gate #(.NONCE_W(NW), .CTR_W(CW), .WINDOW_CYC(WIN), .RETRY_MAX(RMAX),
                    .COOL_CYC(COOL), .DEG_CYC(DEG)) dut (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good), .start_req_i(start_req),
    .nonce_seed_i(seed), .chal_valid_o(chal_valid), .chal_nonce_o(chal_nonce),
    .chal_ctr_o(chal_ctr), .resp_valid_i(resp_valid), .resp_pass_i(resp_pass),
    .resp_ctr_i(resp_ctr), .tamper_i(tamper), .svc_clear_i(svc_clear),
    .policy_i(policy), .en_o(en), .pg_o(pg), .limit_o(limit), .lim_mode_o(lim_mode),
    .alert_o(alert), .cause_o(cause)
  );

  // ---------------- behavioural reference model ----------------
  int m_st, m_win, m_cool, m_deg, m_fails, m_tx, m_last, m_cause, m_mode;
  int m_en, m_lim, m_cv;
  longint m_nonce;

  always @(posedge clk) begin
    int ev, nst;
    bit fl, ld_cool, ld_deg, ld_win;
    if (rst) begin
      m_st = 0; m_win = 0; m_cool = 0; m_deg = 0; m_fails = 0; m_tx = 0; m_last = 0;
      m_cause = 0; m_mode = 0; m_en = 0; m_lim = 0; m_cv = 0; m_nonce = 0;
    end else begin
      ev = 0; fl = 0; ld_cool = 0; ld_deg = 0; ld_win = 0; nst = m_st; m_cv = 0;
      if (m_st == 0) begin
        if (pwr_good && start_req && m_cool == 0 && !tamper) begin
          m_cv = 1; m_tx++; m_nonce = seed; nst = 1; ld_win = 1;
        end
      end else if (m_st == 1) begin
        if (tamper) nst = 0;
        else if (!pwr_good) begin nst = 0; ev = 5; end
        else if (resp_valid) begin
          if (int'(resp_ctr) <= m_last) begin fl = 1; ev = 2; end
          else if (!resp_pass) begin fl = 1; ev = 1; end
          else begin nst = 2; m_last = int'(resp_ctr); m_fails = 0; end
        end else if (m_win <= 1) begin fl = 1; ev = 3; end
      end else if (m_st == 2) begin
        if (tamper) nst = 0;
        else if (!pwr_good) begin nst = 0; ev = 5; end
      end else begin
        if (!pwr_good || m_deg <= 1) nst = 0;
      end
      if (fl) begin
        if (m_fails == RMAX - 1) begin m_fails = 0; ld_cool = 1; end
        else m_fails++;
        if (policy == 2'd1) begin nst = 3; ld_deg = 1; m_mode = 1; end
        else if (policy == 2'd2) begin nst = 3; ld_deg = 1; m_mode = 2; end
        else nst = 0;
      end
      if (nst != 3) m_mode = 0;
      if (tamper) m_cause = 4;
      else if (svc_clear) m_cause = 0;
      else if (m_cause != 4 && ev != 0) m_cause = ev;
      m_win  = ld_win  ? WIN  : (m_win  > 0 ? m_win  - 1 : 0);
      m_cool = ld_cool ? COOL : (m_cool > 0 ? m_cool - 1 : 0);
      m_deg  = ld_deg  ? DEG  : (m_deg  > 0 ? m_deg  - 1 : 0);
      m_st = nst;
      m_en = (nst == 2);
      m_lim = (nst == 3);
    end
  end

  task automatic cmp(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cmp("R1", "en_o", en, m_en);
      cmp("R1", "pg_o", pg, m_en);
      cmp("R2", "chal_valid_o", chal_valid, m_cv);
      cmp("R2", "chal_ctr_o", chal_ctr, m_tx);
      cmp("R2", "chal_nonce_o", chal_nonce, m_nonce);
      cmp("R6", "limit_o", limit, m_lim);
      cmp("R6", "lim_mode_o", lim_mode, m_mode);
      cmp("R11", "cause_o", cause, m_cause);
      cmp("R11", "alert_o", alert, m_cause != 0);
    end
  end

  // open a session; delay < 0 means no response
  task automatic run_session(input int delay, input bit ok, input bit echo,
                             input logic [CW-1:0] cval);
    logic [CW-1:0] got;
    int guard = 0;
    start_req = 1'b1;
    @(negedge clk);
    while (!chal_valid && guard < 300) begin @(negedge clk); guard++; end
    got = chal_ctr;
    start_req = 1'b0;
    seed = seed * 32'd1103515245 + 32'd12345;
    if (delay >= 0) begin
      repeat (delay) @(negedge clk);
      resp_valid = 1'b1; resp_pass = ok; resp_ctr = echo ? got : cval;
      @(negedge clk);
      resp_valid = 1'b0; resp_pass = 1'b0;
    end else begin
      repeat (WIN + 2) @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "reset en_o", en, 0);
    cmp("R11", "reset cause_o", cause, 0);

    // R2: no challenge without power-good
    start_req = 1'b1; n = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (chal_valid) n++; end
    start_req = 1'b0;
    cmp("R2", "challenges while unpowered", n, 0);

    // R1: good session
    pwr_good = 1'b1;
    @(negedge clk);
    run_session(3, 1'b1, 1'b1, '0);
    repeat (2) @(negedge clk);
    cmp("R1", "en after pass", en, 1);
    cmp("R2", "first counter", chal_ctr, 1);

    // R8: brownout while granted
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R8", "en after brownout", en, 0);
    cmp("R8", "cause after brownout", cause, 5);
    pwr_good = 1'b1; svc_clear = 1'b1;
    @(negedge clk); svc_clear = 1'b0;
    @(negedge clk);
    cmp("R11", "alert after clear", alert, 0);

    // R3: replay with pass flag, disconnect policy (failure 1)
    policy = 2'd0;
    run_session(2, 1'b1, 1'b0, 16'd1);
    repeat (2) @(negedge clk);
    cmp("R3", "cause replay", cause, 2);
    cmp("R3", "en on replay", en, 0);
    cmp("R6", "limit on disconnect", limit, 0);

    // R4 + R6 + R7: bad MAC under trickle (failure 2)
    policy = 2'd1;
    run_session(5, 1'b0, 1'b1, '0);
    repeat (2) @(negedge clk);
    cmp("R4", "cause bad mac", cause, 1);
    cmp("R6", "trickle mode", lim_mode, 1);
    cmp("R6", "trickle limit", limit, 1);
    repeat (DEG) @(negedge clk);
    cmp("R7", "limit after degrade expiry", limit, 0);

    // R5 + R9: timeout under disconnect (failure 3) starts cool-down
    policy = 2'd0;
    run_session(-1, 1'b0, 1'b1, '0);
    cmp("R5", "cause timeout", cause, 3);
    start_req = 1'b1; n = 0;
    while (!chal_valid && n < 200) begin @(negedge clk); n++; end
    start_req = 1'b0;
    cmp("R9", "cool-down blocks challenge", (n >= COOL - 6) && (n <= COOL + 2), 1);

    // R5 + R6: the challenge just issued times out under cap policy
    policy = 2'd2;
    repeat (WIN + 2) @(negedge clk);
    cmp("R5", "cause timeout cap", cause, 3);
    cmp("R6", "cap mode", lim_mode, 2);
    cmp("R1", "en low in cap", en, 0);
    repeat (DEG + 2) @(negedge clk);
    cmp("R7", "cap expiry", lim_mode, 0);

    // R10: tamper during a pending session
    policy = 2'd0;
    start_req = 1'b1;
    @(negedge clk); @(negedge clk);
    start_req = 1'b0;
    tamper = 1'b1; @(negedge clk); tamper = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R10", "cause tamper", cause, 4);
    cmp("R10", "en after tamper", en, 0);
    run_session(1, 1'b1, 1'b1, '0);
    repeat (2) @(negedge clk);
    cmp("R10", "session succeeds with alert held", en, 1);
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R10", "tamper not replaced by brownout", cause, 4);
    pwr_good = 1'b1; svc_clear = 1'b1;
    @(negedge clk); svc_clear = 1'b0;
    @(negedge clk);
    cmp("R10", "service clear", cause, 0);
    cmp("R11", "alert cleared", alert, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule